// File: doc/BRIEF.md
# Multi-Region Cartridge Bank Mapper

This block sits between a 13-bit CPU address bus and a 128K ROM plus a 32K RAM. The 4K cartridge window (address line 12 high) is cut into four regions. The low 2K and the 1.5K middle region each show a 2K-aligned segment. A 256-byte upper region shows any single page. The last 256-byte page is fixed and always shows the top page of ROM. Each of the three banked regions has its own bank register. That register says whether the region currently maps ROM or RAM, and which segment it maps.

The CPU changes a bank by touching a hotspot address outside the cartridge window. Reads and writes both count. The low bits of the hotspot address become the new segment number of one region. For every access inside the window, the block drives a ROM or RAM physical address, one chip select, and a RAM write strobe. A ROM image smaller than 128K is served by keeping only the low address bits, so the image repeats across the space.

Top module: `cart_bank_mapper`

## Requirements
- R1: With address line 12 high, the 12-bit offset selects the region. Offsets $000–$7FF are the low region, $800–$DFF the middle region, $E00–$EFF the upper region and $F00–$FFF the fixed page. The fixed page always drives ROM address $1FF00 plus the low offset byte.
- R2: After reset, all three regions map ROM segment 0. The low region shows ROM $00000 + offset, the middle region ROM $18000 + (offset − $800), and the upper region ROM $10000 + low offset byte.
- R3: An access to $0E00–$0E1F sets the low region to ROM bank n, where n is address bits 4:0, giving ROM n×$800 + offset. An access to $0E40–$0E4F sets it to RAM bank n, where n is bits 3:0, giving RAM n×$800 + offset.
- R4: An access to $0F10–$0F1F sets the middle region to ROM $18000 + n×$800, and an access to $0F40–$0F4F sets it to RAM n×$800. In both cases n is bits 3:0, and only the first $600 bytes of the segment appear, at window offsets $800–$DFF.
- R5: An access to $0C00–$0CFF sets the upper region to ROM page $10000 + n×$100, where n is bits 7:0. An access to $0D00–$0D7F sets it to RAM page n×$100, where n is bits 6:0.
- R6: A hotspot access changes only the register of the region it targets, on the clock edge that ends the valid access. Addresses near a hotspot but outside its range, and any cycle with bus_valid low, leave every register unchanged.
- R7: Accesses to $01F4–$01FF never change any bank register.
- R8: During a valid access inside the window, exactly one of rom_cs and ram_cs is high. ram_cs is high only in a banked region currently mapped to RAM. Outside the window, or with bus_valid low, both chip selects are low.
- R9: ram_we is high only during a write cycle to a region mapped to RAM. Writes to ROM-mapped regions and to the fixed page never raise it.
- R10: rom_addr carries the low ROM_AW bits of the 17-bit physical ROM address, so a smaller image repeats across the space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; a bus access ends on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | The current cycle carries a bus access |
| bus_wr | input | 1 | The access is a write |
| bus_addr | input | 13 | CPU address lines |
| rom_addr | output | ROM_AW | ROM physical address |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | 15 | RAM physical address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |

## Verification
The bench builds two copies of the block on one shared bus. One copy uses ROM_AW = 17, which brings all of the 128K ROM within reach, including the top page seen through both the fixed page and the upper region. The other uses ROM_AW = 15, a 32K image, so any selection above 32K can be compared with its mirrored low address. With both copies fed the same hotspot sequence, a wrong bank number shows up as a wrong address in both, while a mistake in trimming the address shows up only in the 32K copy.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CPU_AW  = 13;
  localparam int PHYS_AW = 17;
  localparam int RAM_AW  = 15;
  localparam int NUM_W   = 8;
  localparam int N_REG   = 3;

  typedef enum logic [1:0] {
    RG_LOW = 2'd0,
    RG_MID = 2'd1,
    RG_UP  = 2'd2,
    RG_FIX = 2'd3
  } region_e;

  typedef struct packed {
    logic             is_ram;
    logic [NUM_W-1:0] num;
  } bank_t;

  function automatic region_e region_of(input logic [11:0] off);
    if (!off[11])                 return RG_LOW;
    else if (off[10:9] != 2'b11)  return RG_MID;
    else if (!off[8])             return RG_UP;
    else                          return RG_FIX;
  endfunction

  function automatic logic [PHYS_AW-1:0] rom_phys(input region_e r, input bank_t b,
                                                  input logic [11:0] off);
    case (r)
      RG_LOW:  return (PHYS_AW'(b.num) << 11) | PHYS_AW'(off[10:0]);
      RG_MID:  return 17'h18000 + (PHYS_AW'(b.num) << 11) + PHYS_AW'(off[10:0]);
      RG_UP:   return 17'h10000 | (PHYS_AW'(b.num) << 8) | PHYS_AW'(off[7:0]);
      default: return {9'h1FF, off[7:0]};
    endcase
  endfunction

  function automatic logic [RAM_AW-1:0] ram_phys(input region_e r, input bank_t b,
                                                 input logic [11:0] off);
    if (r == RG_UP) return (RAM_AW'(b.num) << 8) | RAM_AW'(off[7:0]);
    else            return (RAM_AW'(b.num) << 11) | RAM_AW'(off[10:0]);
  endfunction
endpackage

// File: rtl/cbm_hotspot.sv
module cbm_hotspot
  import cbm_pkg::*;
(
  input  logic              valid,
  input  logic [CPU_AW-1:0] addr,
  output logic [N_REG-1:0]  hit,
  output bank_t             val
);
  always_comb begin
    hit = '0;
    val = '0;
    if (valid && !addr[12]) begin
      case (addr[11:8])
        4'hE: begin
          if (addr[7:5] == 3'b000) begin
            hit[RG_LOW] = 1'b1;
            val = '{is_ram: 1'b0, num: {3'b000, addr[4:0]}};
          end else if (addr[7:4] == 4'h4) begin
            hit[RG_LOW] = 1'b1;
            val = '{is_ram: 1'b1, num: {4'h0, addr[3:0]}};
          end
        end
        4'hF: begin
          if (addr[7:4] == 4'h1) begin
            hit[RG_MID] = 1'b1;
            val = '{is_ram: 1'b0, num: {4'h0, addr[3:0]}};
          end else if (addr[7:4] == 4'h4) begin
            hit[RG_MID] = 1'b1;
            val = '{is_ram: 1'b1, num: {4'h0, addr[3:0]}};
          end
        end
        4'hC: begin
          hit[RG_UP] = 1'b1;
          val = '{is_ram: 1'b0, num: addr[7:0]};
        end
        4'hD: begin
          if (!addr[7]) begin
            hit[RG_UP] = 1'b1;
            val = '{is_ram: 1'b1, num: {1'b0, addr[6:0]}};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbm_bank_reg.sv
module cbm_bank_reg
  import cbm_pkg::*;
#(
  parameter bank_t RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  bank_t d,
  output bank_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
  import cbm_pkg::*;
#(
  parameter int ROM_AW = 17
) (
  input  logic              valid,
  input  logic              wr,
  input  logic [CPU_AW-1:0] addr,
  input  bank_t             bank_low,
  input  bank_t             bank_mid,
  input  bank_t             bank_up,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we
);
  region_e            rg;
  bank_t              sel;
  logic               in_win;
  logic [PHYS_AW-1:0] rom_full;

  always_comb begin
    rg     = region_of(addr[11:0]);
    in_win = valid && addr[12];
    case (rg)
      RG_LOW:  sel = bank_low;
      RG_MID:  sel = bank_mid;
      RG_UP:   sel = bank_up;
      default: sel = '0;
    endcase
    rom_full = rom_phys(rg, sel, addr[11:0]);
    ram_addr = ram_phys(rg, sel, addr[11:0]);
    ram_cs   = in_win && (rg != RG_FIX) && sel.is_ram;
    rom_cs   = in_win && !ram_cs;
    ram_we   = ram_cs && wr;
    rom_addr = ROM_AW'(rom_full);
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ROM_AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [12:0]       bus_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [14:0]       ram_addr,
  output logic              ram_cs,
  output logic              ram_we
);
  logic [N_REG-1:0] hs_sel;
  logic             hs_any;
  bank_t            hs_val;
  bank_t            bank_q [N_REG];
  bank_t            bank_low, bank_mid, bank_up;

  cbm_hotspot u_hot (
    .valid (bus_valid),
    .addr  (bus_addr),
    .hit   (hs_sel),
    .val   (hs_val)
  );

  assign hs_any = |hs_sel;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    cbm_bank_reg #(.RST_VAL('0)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (hs_sel[g]),
      .d     (hs_val),
      .q     (bank_q[g])
    );
  end

  assign bank_low = bank_q[RG_LOW];
  assign bank_mid = bank_q[RG_MID];
  assign bank_up  = bank_q[RG_UP];

  cbm_xlate #(.ROM_AW(ROM_AW)) u_xl (
    .valid    (bus_valid),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .bank_low (bank_low),
    .bank_mid (bank_mid),
    .bank_up  (bank_up),
    .rom_addr (rom_addr),
    .rom_cs   (rom_cs),
    .ram_addr (ram_addr),
    .ram_cs   (ram_cs),
    .ram_we   (ram_we)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cbm_pkg::*;
#(
  parameter int ROM_AW = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_wr,
  input logic [12:0]       bus_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              ram_we,
  input logic              hs_any,
  input logic [N_REG-1:0]  hs_sel,
  input bank_t             hs_val,
  input bank_t             bank_low,
  input bank_t             bank_mid,
  input bank_t             bank_up
);
  // R9
  ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && bus_wr));

  // R8
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));

  // R8
  cs_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_addr[12]) |-> (!rom_cs && !ram_cs));

  // R1
  fixed_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[12:8] == 5'h1F) |->
      (rom_cs && rom_addr[7:0] == bus_addr[7:0] && (&rom_addr[ROM_AW-1:8])));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_any |=> ($stable(bank_low) && $stable(bank_mid) && $stable(bank_up)));

  // R6
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_sel));

  // R6
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sel[RG_LOW] |=> (bank_low == $past(hs_val) && $stable(bank_mid) && $stable(bank_up)));

  // R7
  stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr >= 13'h01F4 && bus_addr <= 13'h01FF) |-> !hs_any);
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .rom_addr  (rom_addr),
  .rom_cs    (rom_cs),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .hs_any    (hs_any),
  .hs_sel    (hs_sel),
  .hs_val    (hs_val),
  .bank_low  (bank_low),
  .bank_mid  (bank_mid),
  .bank_up   (bank_up)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;

  logic [16:0] rom_addr;
  logic        rom_cs, ram_cs, ram_we;
  logic [14:0] ram_addr;
  logic [14:0] s_rom_addr;
  logic        s_rom_cs, s_ram_cs, s_ram_we;
  logic [14:0] s_ram_addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_mapper #(.ROM_AW(17)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we)
  );

  cart_bank_mapper #(.ROM_AW(15)) dut_small (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .rom_addr(s_rom_addr), .rom_cs(s_rom_cs), .ram_addr(s_ram_addr), .ram_cs(s_ram_cs),
    .ram_we(s_ram_we)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic [12:0] a, input logic w);
    @(negedge clk);
    bus_addr  = a;
    bus_valid = 1'b1;
    bus_wr    = w;
    #1;
  endtask

  task automatic rom_read(input string tag, input logic [12:0] a, input logic [16:0] exp);
    bus(a, 1'b0);
    chk({tag, " rom_cs"}, 32'(rom_cs), 1);
    chk({tag, " ram_cs"}, 32'(ram_cs), 0);
    chk({tag, " rom_addr"}, 32'(rom_addr), 32'(exp));
  endtask

  task automatic ram_access(input string tag, input logic [12:0] a, input logic w,
                            input logic [14:0] exp);
    bus(a, w);
    chk({tag, " ram_cs"}, 32'(ram_cs), 1);
    chk({tag, " rom_cs"}, 32'(rom_cs), 0);
    chk({tag, " ram_we"}, 32'(ram_we), 32'(w));
    chk({tag, " ram_addr"}, 32'(ram_addr), 32'(exp));
  endtask

  task automatic t_reset;
    rom_read("R2 low", 13'h1123, 17'h00123);
    rom_read("R2 mid", 13'h1900, 17'h18100);
    rom_read("R2 up", 13'h1E05, 17'h10005);
    rom_read("R1 fixed", 13'h1FFC, 17'h1FFFC);
    rom_read("R1 low edge", 13'h17FF, 17'h007FF);
    rom_read("R1 mid edge", 13'h1DFF, 17'h185FF);
  endtask

  task automatic t_lower;
    bus(13'h0E1F, 1'b0);
    rom_read("R3 rom bank31", 13'h1234, 17'h0FA34);
    bus(13'h0E02, 1'b0);
    rom_read("R3 rom bank2", 13'h1000, 17'h01000);
    bus(13'h0E45, 1'b1);
    ram_access("R3 ram write", 13'h1010, 1'b1, 15'h2810);
    ram_access("R3 ram read", 13'h17FF, 1'b0, 15'h2FFF);
  endtask

  task automatic t_middle;
    bus(13'h0F13, 1'b0);
    rom_read("R4 rom top", 13'h1DFF, 17'h19DFF);
    rom_read("R4 rom base", 13'h1800, 17'h19800);
    bus(13'h0F4A, 1'b0);
    ram_access("R4 ram write", 13'h1800, 1'b1, 15'h5000);
    ram_access("R4 ram top", 13'h1DFF, 1'b0, 15'h55FF);
    ram_access("R6 low untouched", 13'h1010, 1'b0, 15'h2810);
  endtask

  task automatic t_upper;
    bus(13'h0CFF, 1'b0);
    rom_read("R5 rom top page", 13'h1E10, 17'h1FF10);
    chk("R10 small mirror", 32'(s_rom_addr), 32'h7F10);
    bus(13'h0C00, 1'b0);
    rom_read("R5 rom page0", 13'h1EAB, 17'h100AB);
    bus(13'h0D7F, 1'b0);
    ram_access("R5 ram write", 13'h1E10, 1'b1, 15'h7F10);
    ram_access("R6 mid untouched", 13'h1800, 1'b0, 15'h5000);
  endtask

  task automatic state_unchanged(input string tag);
    ram_access({tag, " low"}, 13'h1010, 1'b0, 15'h2810);
    ram_access({tag, " mid"}, 13'h1800, 1'b0, 15'h5000);
    ram_access({tag, " up"}, 13'h1E10, 1'b0, 15'h7F10);
  endtask

  task automatic t_ignore;
    bus(13'h0E20, 1'b0);
    bus(13'h0E50, 1'b1);
    bus(13'h0F20, 1'b0);
    bus(13'h0F50, 1'b0);
    bus(13'h0D80, 1'b1);
    bus(13'h0B00, 1'b0);
    @(negedge clk);
    bus_addr  = 13'h0E00;
    bus_valid = 1'b0;
    @(negedge clk);
    bus_addr  = 13'h0C12;
    #1;
    chk("R8 idle rom_cs", 32'(rom_cs), 0);
    state_unchanged("R6 near-miss");
    for (int a = 13'h01F4; a <= 13'h01FF; a++) bus(13'(a), a[0]);
    state_unchanged("R7 stack");
  endtask

  task automatic t_chipsel;
    bus(13'h0080, 1'b0);
    chk("R8 outside rom_cs", 32'(rom_cs), 0);
    chk("R8 outside ram_cs", 32'(ram_cs), 0);
    bus(13'h1FFC, 1'b1);
    chk("R9 fixed write we", 32'(ram_we), 0);
    chk("R1 fixed under ram up", 32'(rom_addr), 32'h1FFFC);
    chk("R1 fixed rom_cs", 32'(rom_cs), 1);
    bus(13'h0E02, 1'b0);
    bus(13'h1000, 1'b1);
    chk("R9 rom write we", 32'(ram_we), 0);
    chk("R9 rom write cs", 32'(rom_cs), 1);
    chk("R10 small low", 32'(s_rom_addr), 32'h1000);
    bus(13'h0C80, 1'b0);
    rom_read("R5 rom page80", 13'h1E00, 17'h18000);
    chk("R10 small up", 32'(s_rom_addr), 32'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset rom_cs", 32'(rom_cs), 0);
    rst_n = 1'b1;
    t_reset;
    t_lower;
    t_middle;
    t_upper;
    t_ignore;
    t_chipsel;
    @(negedge clk);
    bus_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule